// File: doc/BRIEF.md
# Banked GPIO Controller with Password-Gated Pin Claiming

This block is a register-mapped general-purpose I/O controller on a simple 32-bit write/read bus. Pins are grouped in banks of 32, and the number of banks is a parameter (default 2, so 64 pins). A global pin number `n` belongs to bank `n >> 5`, at bit `n & 31` of that bank's registers. Software never writes the output register directly. It raises bits through a write-one-to-set register and lowers them through a write-one-to-clear register, so two agents can each change their own pins without a read-modify-write race.

Each pin has its own control word. The word selects the pin's direction and stores an edge-trigger type and a debounce setting that software can read back. Inputs reach the register map through a two-flop synchroniser. Each bank also has a claim (lock) status register. Writes to it go through only after the password `0x00A5A501` has been written to a key register. One correct key write permits exactly one claim-register write.

The read path is combinational: `bus_rdata` reflects `bus_addr` in the same cycle. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every output bit is 0, every output enable is 0, every claim status bit is 1, and every control word reads 0x00000001.
- R2: A write to the set register of bank b (offset 0x040 + 4b) makes each output bit of that bank whose data bit is 1 equal to 1 at the next edge. Bits whose data bit is 0 keep their value. `pin_out` follows the output register.
- R3: A write to the clear register of bank b (offset 0x060 + 4b) makes each output bit whose data bit is 1 equal to 0. Bits whose data bit is 0 keep their value.
- R4: Reads of the output status (0x000 + 4b), set, and clear offsets of a bank all return that bank's current output register.
- R5: A read of input status (0x020 + 4b) returns the bank's pin levels as they were two clock edges earlier (two-flop synchroniser).
- R6: The control word of pin n sits at 0x100 + 4n. Bit 0 is direction (1 = input, 0 = output), bits 4:3 are the trigger type, and bits 8:5 are the debounce setting. These bits read back as written, and all other bits read 0.
- R7: `pin_oe[n]` is 1 exactly when bit 0 of pin n's control word is 0. The enable follows at the edge after the control write.
- R8: A write to a claim status register (0x500 + 4b) while no unlock is pending leaves that register unchanged.
- R9: Writing 0x00A5A501 to the key register (0x520) arms a single unlock. The next claim-register write, to any bank, stores its data and disarms the unlock. Other writes in between do not disarm it.
- R10: Any write to the key register with a value other than 0x00A5A501 cancels a pending unlock.
- R11: Reads of the key register, of unaligned addresses, of bank or pin slots beyond the configured count, and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 12 | Byte address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | BANKS*32 | Pin levels from the pads (asynchronous) |
| pin_out | output | BANKS*32 | Output level for each pin |
| pin_oe | output | BANKS*32 | Output enable for each pin |

## Verification
Most internal faults in this block show up at the ports within one edge of the write that exposes them. A corrupted set or clear mask shows immediately on `pin_out` in bits that should have kept their value. A wrong direction bit flips `pin_oe` one edge after the control write. The unlock flag is never visible directly; a fault in it only shows when the next claim-register write lands or fails to land. The bench therefore reads the claim register back after every lock attempt. It also times input readback edge by edge, so that a missing or extra synchroniser stage is caught.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int unsigned WORD_W       = 32;
   localparam int unsigned PINS_PER_BK  = 32;
   localparam int unsigned ADDR_W       = 12;
   localparam int unsigned MAX_BANKS    = 8;
   localparam int unsigned BANK_SEL_W   = 3;
   localparam int unsigned PIN_SEL_W    = 8;

   localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h100;
   localparam logic [ADDR_W-1:0] OFS_KEY  = 12'h520;
   localparam logic [6:0]        LOCK_PAGE = 7'h28;   // 0x500 >> 5
   localparam logic [WORD_W-1:0] UNLOCK_KEY = 32'h00A5A501;

   typedef enum logic [2:0] {
      RG_NONE, RG_OUT, RG_IN, RG_SET, RG_CLR, RG_CFG, RG_LOCK, RG_KEY
   } reg_kind_e;

   // stored control fields; bits 2:1 and 31:9 are not kept
   typedef struct packed {
      logic [3:0] dbnc;     // word bits 8:5
      logic [1:0] trig;     // word bits 4:3
      logic       dir_in;   // word bit 0
   } pin_cfg_t;

   localparam pin_cfg_t CFG_RST = '{dbnc: 4'h0, trig: 2'h0, dir_in: 1'b1};

   function automatic pin_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
      cfg_from_word = '{dbnc: w[8:5], trig: w[4:3], dir_in: w[0]};
   endfunction

   function automatic logic [WORD_W-1:0] cfg_to_word(input pin_cfg_t c);
      cfg_to_word = {23'd0, c.dbnc, c.trig, 2'b00, c.dir_in};
   endfunction
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
   import pinbank_pkg::*;
#(
   parameter int unsigned BANKS = 2
) (
   input  logic [ADDR_W-1:0]     addr,
   output reg_kind_e             kind,
   output logic [BANK_SEL_W-1:0] bank_sel,
   output logic [PIN_SEL_W-1:0]  pin_sel
);
   localparam int unsigned PINS = BANKS * PINS_PER_BK;

   logic [9:0] word_idx;
   logic [9:0] cfg_idx;
   logic       aligned;
   logic       bank_ok;

   assign word_idx = addr[11:2];
   assign cfg_idx  = word_idx - 10'h040;
   assign aligned  = (addr[1:0] == 2'b00);
   assign bank_sel = addr[4:2];
   assign bank_ok  = (32'(bank_sel) < BANKS);
   assign pin_sel  = cfg_idx[PIN_SEL_W-1:0];

   always_comb begin
      kind = RG_NONE;
      if (aligned) begin
         if (addr[11:7] == 5'd0) begin
            if (bank_ok) begin
               unique case (addr[6:5])
                  2'd0: kind = RG_OUT;
                  2'd1: kind = RG_IN;
                  2'd2: kind = RG_SET;
                  default: kind = RG_CLR;
               endcase
            end
         end else if (addr >= OFS_CFG && 32'(cfg_idx) < PINS) begin
            kind = RG_CFG;
         end else if (addr[11:5] == LOCK_PAGE) begin
            if (bank_ok) kind = RG_LOCK;
         end else if (addr == OFS_KEY) begin
            kind = RG_KEY;
         end
      end
   end
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pinbank_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= (s == 0) ? d_async : chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pinbank_outreg.sv
module pinbank_outreg #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] level_q
);
   logic [WIDTH-1:0] set_m;
   logic [WIDTH-1:0] clr_m;

   assign set_m = set_we ? mask : '0;
   assign clr_m = clr_we ? mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else        level_q <= (level_q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/pinbank_lockgate.sv
module pinbank_lockgate
   import pinbank_pkg::*;
#(
   parameter int unsigned BANKS = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  key_we,
   input  logic                  lock_we,
   input  logic [BANK_SEL_W-1:0] lock_bank,
   input  logic [WORD_W-1:0]     wdata,
   output logic                  armed,
   output logic [WORD_W-1:0]     claim_q [BANKS]
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed_q <= 1'b0;
      else if (key_we)  armed_q <= (wdata == UNLOCK_KEY);
      else if (lock_we) armed_q <= 1'b0;
   end

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               claim_q[b] <= '1;
            else if (lock_we && armed_q && lock_bank == BANK_SEL_W'(b))
               claim_q[b] <= wdata;
         end
      end
   endgenerate

   assign armed = armed_q;
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
   import pinbank_pkg::*;
#(
   parameter int unsigned BANKS = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PINS = BANKS * PINS_PER_BK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [11:0]       bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe
);
   generate
      if (BANKS < 1 || BANKS > MAX_BANKS) begin : g_bad_banks
         $error("pinbank_ctrl: BANKS must lie in 1..8");
      end
   endgenerate

   reg_kind_e             kind;
   logic [BANK_SEL_W-1:0] bank_sel;
   logic [PIN_SEL_W-1:0]  pin_sel;
   logic [WORD_W-1:0]     out_q   [BANKS];
   logic [WORD_W-1:0]     in_s    [BANKS];
   logic [WORD_W-1:0]     claim_q [BANKS];
   pin_cfg_t              cfg_q   [PINS];
   logic                  unlock_armed;
   logic [WORD_W-1:0]     claim_bank0;

   pinbank_decode #(.BANKS(BANKS)) u_dec (
      .addr(bus_addr), .kind(kind), .bank_sel(bank_sel), .pin_sel(pin_sel)
   );

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         pinbank_outreg #(.WIDTH(WORD_W)) u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (bus_wr && kind == RG_SET && bank_sel == BANK_SEL_W'(b)),
            .clr_we (bus_wr && kind == RG_CLR && bank_sel == BANK_SEL_W'(b)),
            .mask   (bus_wdata),
            .level_q(out_q[b])
         );
         pinbank_sync #(.WIDTH(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .d_async(pin_in[b*PINS_PER_BK +: PINS_PER_BK]),
            .q_sync (in_s[b])
         );
         assign pin_out[b*PINS_PER_BK +: PINS_PER_BK] = out_q[b];
      end

      for (genvar p = 0; p < PINS; p++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q[p] <= CFG_RST;
            else if (bus_wr && kind == RG_CFG && pin_sel == PIN_SEL_W'(p))
               cfg_q[p] <= cfg_from_word(bus_wdata);
         end
         assign pin_oe[p] = ~cfg_q[p].dir_in;
      end
   endgenerate

   pinbank_lockgate #(.BANKS(BANKS)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (bus_wr && kind == RG_KEY),
      .lock_we  (bus_wr && kind == RG_LOCK),
      .lock_bank(bank_sel),
      .wdata    (bus_wdata),
      .armed    (unlock_armed),
      .claim_q  (claim_q)
   );

   assign claim_bank0 = claim_q[0];

   always_comb begin
      bus_rdata = '0;
      unique case (kind)
         RG_OUT, RG_SET, RG_CLR: begin
            for (int b = 0; b < BANKS; b++)
               if (bank_sel == BANK_SEL_W'(b)) bus_rdata = out_q[b];
         end
         RG_IN: begin
            for (int b = 0; b < BANKS; b++)
               if (bank_sel == BANK_SEL_W'(b)) bus_rdata = in_s[b];
         end
         RG_LOCK: begin
            for (int b = 0; b < BANKS; b++)
               if (bank_sel == BANK_SEL_W'(b)) bus_rdata = claim_q[b];
         end
         RG_CFG: begin
            for (int p = 0; p < PINS; p++)
               if (pin_sel == PIN_SEL_W'(p)) bus_rdata = cfg_to_word(cfg_q[p]);
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
   import pinbank_pkg::*;
#(
   parameter int unsigned BANKS = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic [11:0] bus_addr,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic [31:0] in_lo,
   input logic [31:0] out_lo,
   input logic [31:0] oe_lo,
   input logic        armed,
   input logic [31:0] claim0
);
   logic [1:0] age_q;
   logic       lock_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= 2'd0;
      else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
   end

   assign lock_hit = bus_wr && bus_addr[11:5] == LOCK_PAGE && bus_addr[1:0] == 2'b00
                     && 32'(bus_addr[4:2]) < BANKS;

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (out_lo == 32'd0 && oe_lo == 32'd0));

   assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 12'h040) |=> ((out_lo & $past(bus_wdata)) == $past(bus_wdata)));

   assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 12'h060) |=> ((out_lo & $past(bus_wdata)) == 32'd0));

   assert_in_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2 && bus_addr == 12'h020) |-> (bus_rdata == $past(in_lo, 2)));

   assert_oe_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CFG) |=> (oe_lo[0] == !$past(bus_wdata[0])));

   assert_lock_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 12'h500 && !armed) |=> $stable(claim0));

   assert_unlock_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_hit && armed) |=> !armed);

   assert_bad_key_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_KEY && bus_wdata != UNLOCK_KEY) |=> !armed);

   assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= 12'h600 || bus_addr == OFS_KEY) |-> (bus_rdata == 32'd0));
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(.BANKS(BANKS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .in_lo    (pin_in[31:0]),
   .out_lo   (pin_out[31:0]),
   .oe_lo    (pin_oe[31:0]),
   .armed    (unlock_armed),
   .claim0   (claim_bank0)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb_top;
   localparam int BANKS = 2;
   localparam int PINS  = BANKS * 32;
   localparam int KIND_RD = 0, KIND_OUT = 1, KIND_OE = 2;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [PINS-1:0] pin_in = '0;
   logic [PINS-1:0] pin_out;
   logic [PINS-1:0] pin_oe;

   int       n_checks = 0;
   int       n_fail   = 0;
   bit       done     = 1'b0;
   sb_item_t sb_q[$];

   always #4 clk = ~clk;   // 125 MHz

   pinbank_ctrl #(.BANKS(BANKS)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // monitor: drains the scoreboard at each falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
               KIND_OUT: act = pin_out[31:0];
               KIND_OE:  act = pin_oe[31:0];
               default:  act = bus_rdata;
            endcase
            n_checks++;
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
            end
         end
      end
   end

   // driver tasks: called just after a rising edge
   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic expect_item(input int k, input logic [11:0] a,
                              input logic [31:0] e, input string tag);
      sb_item_t it;
      bus_addr = a;
      it.kind = k; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      @(posedge clk); #1;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      expect_item(KIND_RD, a, e, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      rd(12'h000, 32'h0, "R1 out bank0");
      rd(12'h004, 32'h0, "R1 out bank1");
      rd(12'h500, 32'hFFFF_FFFF, "R1 claim bank0");
      rd(12'h504, 32'hFFFF_FFFF, "R1 claim bank1");
      rd(12'h100, 32'h1, "R1 cfg pin0");
      rd(12'h1FC, 32'h1, "R1 cfg pin63");
      expect_item(KIND_OE, 12'h0, 32'h0, "R1 oe low");

      // R7 direction: pins 0..7 to output
      for (int p = 0; p < 8; p++) wr(12'h100 + 12'(4*p), 32'h0);
      expect_item(KIND_OE, 12'h0, 32'h0000_00FF, "R7 oe after dir writes");

      // R2 / R3 set and clear
      wr(12'h040, 32'h0000_00A5);
      expect_item(KIND_OUT, 12'h0, 32'h0000_00A5, "R2 set pin_out");
      wr(12'h040, 32'h0000_000F);
      rd(12'h000, 32'h0000_00AF, "R2 set keeps other bits");
      wr(12'h060, 32'h0000_0081);
      rd(12'h000, 32'h0000_002E, "R3 clear");
      rd(12'h040, 32'h0000_002E, "R4 read via set offset");
      rd(12'h060, 32'h0000_002E, "R4 read via clear offset");
      wr(12'h040, 32'hFFFF_0000);
      expect_item(KIND_OUT, 12'h0, 32'hFFFF_002E, "R2 upper set, lower kept");
      wr(12'h060, 32'h0F0F_0000);
      rd(12'h000, 32'hF0F0_002E, "R3 partial clear");
      wr(12'h044, 32'h0000_0100);
      rd(12'h044, 32'h0000_0100, "R4 bank1 status");
      rd(12'h000, 32'hF0F0_002E, "R2 bank0 untouched by bank1 set");

      // R6 control word fields
      wr(12'h114, 32'hFFFF_FFFE);
      rd(12'h114, 32'h0000_01F8, "R6 cfg pin5 stored bits");
      wr(12'h118, 32'h0000_0019);
      rd(12'h118, 32'h0000_0019, "R6 cfg pin6 trig and dir");
      expect_item(KIND_OE, 12'h0, 32'h0000_00BF, "R7 pin6 back to input");

      // R5 input synchroniser latency
      pin_in = {32'hCAFE_0001, 32'h1234_5678};
      rd(12'h020, 32'h0, "R5 input before first edge");
      rd(12'h020, 32'h0, "R5 input after one edge");
      rd(12'h020, 32'h1234_5678, "R5 input after two edges");
      rd(12'h024, 32'hCAFE_0001, "R5 bank1 input");

      // R8 claim write without unlock
      wr(12'h500, 32'h0);
      rd(12'h500, 32'hFFFF_FFFF, "R8 claim unchanged without key");
      // R9 single-use unlock
      wr(12'h520, 32'h00A5_A501);
      wr(12'h500, 32'hFFFF_FFFE);
      rd(12'h500, 32'hFFFF_FFFE, "R9 claim after key");
      wr(12'h500, 32'h0);
      rd(12'h500, 32'hFFFF_FFFE, "R9 unlock consumed");
      // R10 wrong key cancels
      wr(12'h520, 32'h00A5_A501);
      wr(12'h520, 32'h00A5_A500);
      wr(12'h504, 32'h0);
      rd(12'h504, 32'hFFFF_FFFF, "R10 wrong key cancels");
      // R9 other writes do not disarm; any bank consumes
      wr(12'h520, 32'h00A5_A501);
      wr(12'h040, 32'h0000_0001);
      wr(12'h504, 32'h0000_FFFF);
      rd(12'h504, 32'h0000_FFFF, "R9 key survives other writes");
      rd(12'h500, 32'hFFFF_FFFE, "R9 other bank untouched");

      // R11 unmapped reads
      rd(12'h520, 32'h0, "R11 key register reads zero");
      rd(12'h600, 32'h0, "R11 above map");
      rd(12'h028, 32'h0, "R11 bank beyond count");
      rd(12'h200, 32'h0, "R11 pin beyond count");
      rd(12'h0A0, 32'h0, "R11 gap");
      rd(12'h001, 32'h0, "R11 unaligned");
      rd(12'h508, 32'h0, "R11 claim beyond count");

      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule